// File: doc/BRIEF.md
# Burst Address Sequencer for Four-Beat SRAM Bursts

This block produces the address that a synchronous SRAM core uses for each beat of a burst. A new command (advance/load low while clock enable is active) captures a base address. Each following burst-continue cycle (advance/load high, clock enable active) moves a beat counter forward. The low address bits come from the base low bits and that counter. The upper bits always come from the captured base and are never altered.

A burst-order select input picks one of two sequences. In linear order the count is added to the base low bits, wrapping within the burst. In interleaved order the count is XORed with the base low bits. The select is meant to be tied to a fixed level. The output mapping follows its present value. When clock enable is low, all state holds, whatever the other inputs do. A four-beat burst wraps back to its starting address and keeps cycling if continue cycles go on.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears the stored base and the beat count, so `addr_out` reads all zeros after a reset edge.
- R2: At a rising edge with `ce`=1 and `adv_ld`=0, `base_addr` is captured and the count restarts at zero, so `addr_out` equals that `base_addr` after the edge. This also applies in the middle of a burst.
- R3: With `order_sel`=0 (linear), after n continue edges following a load, the low two bits of `addr_out` equal (base low bits + n) mod 4. For example, start 2 gives 2,3,0,1.
- R4: With `order_sel`=1 (interleaved), after n continue edges, the low two bits of `addr_out` equal base low bits XOR (n mod 4). For example, start 1 gives 1,0,3,2.
- R5: After four continue edges the output returns to the loaded base address, in either order.
- R6: Bits [ADDR_W-1:2] of `addr_out` stay equal to the loaded base during continue cycles. Changes on `base_addr` while `adv_ld`=1 have no effect on `addr_out`.
- R7: A rising edge with `ce`=0 changes no state, whatever `adv_ld` and `base_addr` are. With `order_sel` held, `addr_out` stays unchanged.
- R8: The low bits of `addr_out` follow `order_sel` without a clock edge: the current count is mapped through the order that `order_sel` presently selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable; low freezes all state |
| adv_ld | input | 1 | 0 = load new base, 1 = continue burst |
| base_addr | input | ADDR_W | Base address captured on a load |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_out | output | ADDR_W | Address for the current beat |

## Verification
The bench loads start values where the linear and interleaved sequences differ and where they agree. A design that used the wrong one of add and XOR fails at start 1 or 3 but not at start 0 or 2. It runs full bursts and then a fifth continue. A counter wider than the burst, or one that saturates, misses the return to the base address. It drops `ce` while `adv_ld` is low and `base_addr` changes, which exposes a design that lets a load bypass clock enable. It changes `base_addr` during continue cycles and reloads in the middle of a burst. This catches a design that tracks the input instead of the captured base, or one that fails to restart the count on a load.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int unsigned BURST_BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } burst_cmd_e;

    function automatic burst_cmd_e decode_cmd(input logic ce, input logic adv_ld);
        burst_cmd_e c;
        if (!ce)
            c = CMD_HOLD;
        else if (!adv_ld)
            c = CMD_LOAD;
        else
            c = CMD_STEP;
        return c;
    endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_e        cmd,
    input  logic [ADDR_W-1:0] base_in,
    output logic [ADDR_W-1:0] base_q
);
    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (cmd == CMD_LOAD)
            base_q <= base_in;
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int unsigned BEAT_W = BURST_BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_e        cmd,
    output logic [BEAT_W-1:0] cnt_q
);
    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD: cnt_q <= '0;
                CMD_STEP: cnt_q <= cnt_q + ONE;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int unsigned BEAT_W = BURST_BEAT_W
) (
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  burst_order_e      order,
    output logic [BEAT_W-1:0] lo_out
);
    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    assign lin_lo = start_lo + beat;

    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
        assign ilv_lo[i] = start_lo[i] ^ beat[i];
    end

    always_comb begin
        unique case (order)
            ORD_INTERLEAVE: lo_out = ilv_lo;
            default:        lo_out = lin_lo;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned BEAT_W = BURST_BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              adv_ld,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int unsigned HI_W = ADDR_W - BEAT_W;

    burst_cmd_e        cmd;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] lo_now;

    assign cmd = decode_cmd(ce, adv_ld);

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .base_in (base_addr),
        .base_q  (base_q)
    );

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .cnt_q (cnt_q)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .start_lo (base_q[BEAT_W-1:0]),
        .beat     (cnt_q),
        .order    (burst_order_e'(order_sel)),
        .lo_out   (lo_now)
    );

    assign addr_out = {base_q[ADDR_W-1 -: HI_W], lo_now};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned BEAT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ce,
    input logic              adv_ld,
    input logic [ADDR_W-1:0] base_addr,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_out
);
    AST_LOAD_TAKES_BASE: assert property (@(posedge clk) disable iff (rst)
        (ce && !adv_ld) |=> (addr_out == $past(base_addr)));  // R2

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (ce && adv_ld && !order_sel) |=>
        (order_sel || (addr_out[BEAT_W-1:0] == ($past(addr_out[BEAT_W-1:0]) + BEAT_W'(1)))));  // R3

    AST_ILV_LSB_FLIP: assert property (@(posedge clk) disable iff (rst)
        (ce && adv_ld && order_sel) |=>
        (!order_sel || (addr_out[0] != $past(addr_out[0]))));  // R4

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (ce && adv_ld) |=> (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));  // R6

    AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
        (!ce) |=> (!$stable(order_sel) || $stable(addr_out)));  // R7
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .adv_ld    (adv_ld),
    .base_addr (base_addr),
    .order_sel (order_sel),
    .addr_out  (addr_out)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce = 1'b0;
    logic          adv_ld = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) dut (
        .clk(clk), .rst(rst), .ce(ce), .adv_ld(adv_ld),
        .base_addr(base_addr), .order_sel(order_sel), .addr_out(addr_out)
    );

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input logic [1:0] n,
                                               input logic ord);
        logic [1:0] lo;
        lo = ord ? (b[1:0] ^ n) : (b[1:0] + n);
        return {b[AW-1:2], lo};
    endfunction

    task automatic check(input string tag);
        logic [AW-1:0] e;
        e = exp_addr(m_base, m_cnt, order_sel);
        checks++;
        if (addr_out !== e) begin
            errors++;
            $display("FAIL %s addr_out=%h expected=%h", tag, addr_out, e);
        end
    endtask

    // drive at negedge, take the edge, update the model, check at the next negedge
    task automatic cyc(input logic c, input logic a, input logic [AW-1:0] b, input logic o,
                       input string tag);
        ce = c; adv_ld = a; base_addr = b; order_sel = o;
        @(posedge clk);
        if (rst) begin
            m_base = '0; m_cnt = '0;
        end else if (c && !a) begin
            m_base = b; m_cnt = '0;
        end else if (c) begin
            m_cnt = m_cnt + 2'd1;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] start;
        process::self().srandom(32'd1234);
        @(negedge clk);
        cyc(1'b1, 1'b0, 20'hABCDE, 1'b1, "R1 reset");
        cyc(1'b1, 1'b1, 20'h12345, 1'b0, "R1 reset");
        rst = 1'b0;

        // R3 linear from start 2, then wrap R5
        cyc(1'b1, 1'b0, 20'h5A5A6, 1'b0, "R2 load");
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 20'h00000, 1'b0, "R3 linear step");
        cyc(1'b1, 1'b1, 20'hFFFFF, 1'b0, "R5 linear wrap");
        if (addr_out !== 20'h5A5A6) begin errors++; $display("FAIL R5 addr_out=%h expected=%h", addr_out, 20'h5A5A6); end
        checks++;

        // R4 interleaved from start 1, then wrap R5
        cyc(1'b1, 1'b0, 20'h3C3C1, 1'b1, "R2 load");
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 20'h00003, 1'b1, "R4 interleave step");
        cyc(1'b1, 1'b1, 20'h00000, 1'b1, "R5 interleave wrap");
        cyc(1'b1, 1'b1, 20'h00000, 1'b1, "R5 fifth beat");

        // R7 hold with ce low, including a would-be load
        cyc(1'b0, 1'b0, 20'h77777, 1'b1, "R7 hold on load");
        cyc(1'b0, 1'b1, 20'h11111, 1'b1, "R7 hold on step");

        // R8 order select maps current count immediately
        cyc(1'b1, 1'b0, 20'h00003, 1'b0, "R2 load");
        cyc(1'b1, 1'b1, 20'h00000, 1'b0, "R3 linear step");
        order_sel = 1'b1; #1; check("R8 switch to interleave");
        order_sel = 1'b0; #1; check("R8 switch to linear");

        // R6 base changes during continue ignored; R2 reload mid-burst
        cyc(1'b1, 1'b1, 20'hFFFFC, 1'b0, "R6 base ignored");
        cyc(1'b1, 1'b0, 20'h80002, 1'b0, "R2 reload mid burst");

        // random mix
        for (int i = 0; i < 600; i++) begin
            start = AW'($urandom);
            cyc(($urandom % 5) != 0, ($urandom % 4) != 0, start, (i / 150) % 2 == 1,
                "R2 R3 R4 R6 R7 random");
        end

        // R1 reset mid-run
        rst = 1'b1;
        cyc(1'b1, 1'b1, 20'h0F0F0, 1'b1, "R1 reset mid run");
        rst = 1'b0;
        cyc(1'b1, 1'b1, 20'h0F0F0, 1'b1, "R1 step after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule